// File: doc/BRIEF.md
# TRS Word Framer

This block sits behind the serial line decoder of a digital video receiver. It takes the recovered bit stream one bit at a time, qualified by a valid strobe, and cuts it into 10-bit words. The bits of each word arrive least-significant first. It watches every bit position for the four-word timing reference sequence that starts or ends each active video line: an all-ones word, two all-zeros words, and a flag word whose bit 6 tells an end of active video from a start. When framing is enabled and the sequence appears off the current word boundary, the block moves its word boundary onto the sequence.

The word stream leaves the block three word periods after the bits that complete it. This lets the active-low reference flag cover all four words of a sequence as they are emitted. The active-low end-of-video flag marks the flag word alone, and only for component video. An active-high flag reports that the latest reference sequence sat at a different bit offset than the word boundary in use.

Top module: `trs_word_framer`

## Requirements
- R1: Once the word boundary is fixed, the block pulses word_stb for one cycle for every 10 accepted bits. The first bit received of a word is bit 0 of word_out.
- R2: A reference sequence is the words 10'h3FF, 10'h000, 10'h000 and any flag word, in that order. It is found at whatever bit offset it starts.
- R3: trs_n is low for the four word periods in which the words 3FF, 000, 000 and the flag word of an accepted sequence are presented on word_out, and high otherwise.
- R4: For component video (composite=0), eav_n is low for exactly the one word period that presents a flag word with bit 6 set. That word is the fourth word of the sequence.
- R5: With composite=1, eav_n stays high.
- R6: With frame_en=1, a sequence found off the current boundary is accepted. Its flag word is emitted whole, no partial word is emitted, and every later word starts on the new boundary.
- R7: With frame_en=0, the word boundary never moves. A sequence found off the boundary raises neither trs_n nor eav_n, and the strobe count stays one per 10 bits.
- R8: nsp goes high when a sequence is found off the current boundary. It goes low when a sequence is found on the boundary.
- R9: Output latency is three words. The 3FF word of a sequence is presented on the strobe caused by the completion of its flag word.
- R10: While rst_n is low at a clock edge, the outputs take word_out=0, word_stb=0, trs_n=1, eav_n=1 and nsp=0.
- R11: Cycles with bit_vld low shift nothing and advance no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_bit | input | 1 | Decoded serial data bit |
| ser_vld | input | 1 | ser_bit is valid in this cycle |
| frame_en | input | 1 | Allows the word boundary to move onto a found sequence |
| composite | input | 1 | 1 = composite video, end-of-video flag held high |
| word_out | output | 10 | Parallel word, bit 0 received first |
| word_stb | output | 1 | One-cycle pulse for each new word_out |
| trs_n | output | 1 | Low while a reference sequence word is presented |
| eav_n | output | 1 | Low while an end-of-video flag word is presented |
| nsp | output | 1 | Latest sequence was off the word boundary |

## Verification
When a sequence turns up off the boundary with framing enabled, three things happen on the bit that completes the flag word. The old boundary gives up its partial word, a word strobe is forced, and the output stage reloads with the sequence and its flags. The nsp flag also rises in that same cycle. The bench provokes this with random lead-in lengths that are not multiples of ten, and with random gaps in the valid strobe. It judges the outcome by matching every emitted word and flag against a sequence built from the words it sent.

// File: rtl/sdv_frm_pkg.sv
// Package: shared default geometry of the TRS word framer.
// Assumes a reference sequence has at least three words.
package sdv_frm_pkg;
    localparam int unsigned WORD_W_DEF    = 10;  // bits per word
    localparam int unsigned TRS_WORDS_DEF = 4;   // words per reference sequence
    localparam int unsigned H_BIT_DEF     = 6;   // end-of-video bit in the flag word
endpackage

// File: rtl/trs_window.sv
// Sliding window over the serial stream. Every accepted bit is shifted in at
// the top, so the oldest bit sits at bit 0. hit fires in the cycle whose bit
// completes ones-word, zero-words, flag-word at any bit offset.
// Assumes N >= 3 and bits least-significant first.
module trs_window #(
    parameter int unsigned W = sdv_frm_pkg::WORD_W_DEF,
    parameter int unsigned N = sdv_frm_pkg::TRS_WORDS_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    input  logic         bit_vld,
    output logic         hit,
    output logic [W-1:0] last_word
);
    localparam int unsigned SR_W = W * N;

    logic [SR_W-1:0] sr;
    logic [SR_W-1:0] nxt;

    // Window contents after the present bit is taken in.
    always_comb nxt = {bit_in, sr[SR_W-1:1]};

    // Shift only on accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr <= '0;
        else if (bit_vld) sr <= nxt;
    end

    // Pattern compare on the post-shift window.
    always_comb begin
        hit       = bit_vld && (nxt[W-1:0] == '1) && (nxt[SR_W-W-1:W] == '0);
        last_word = nxt[SR_W-1 -: W];
    end
endmodule

// File: rtl/word_phase.sv
// Bit position within the current word. A word ends on its last bit, or early
// when an off-boundary sequence is accepted with framing enabled. Then the
// flag word closes a word and the count restarts on the next bit.
// Assumes hit is only asserted together with bit_vld.
module word_phase #(
    parameter int unsigned W = sdv_frm_pkg::WORD_W_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic hit,
    input  logic frame_en,
    output logic done,
    output logic accept,
    output logic misaligned
);
    localparam int unsigned PH_W = $clog2(W);
    localparam logic [PH_W-1:0] LAST = PH_W'(W - 1);

    logic [PH_W-1:0] phase;
    logic            at_end;

    // Word-end and acceptance decisions.
    always_comb begin
        at_end     = (phase == LAST);
        done       = bit_vld && (at_end || (hit && frame_en));
        accept     = hit && (at_end || frame_en);
        misaligned = hit && !at_end;
    end

    // Bit counter, restarted at every word end.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (done)    phase <= '0;
        else if (bit_vld) phase <= phase + PH_W'(1);
    end

    // R7: with framing off an off-boundary sequence leaves the boundary alone
    p_hold_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_en && misaligned) |=> (phase == $past(phase) + PH_W'(1)));
endmodule

// File: rtl/word_pipe.sv
// Output stage. It holds N-1 completed words so that all N words of an
// accepted sequence are known before the first is shown. On acceptance it
// reloads with the known sequence words and their flags. Otherwise it shifts
// one word per completion.
// Assumes N >= 3 and done at most once per cycle.
module word_pipe #(
    parameter int unsigned W  = sdv_frm_pkg::WORD_W_DEF,
    parameter int unsigned N  = sdv_frm_pkg::TRS_WORDS_DEF,
    parameter int unsigned HB = sdv_frm_pkg::H_BIT_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         done,
    input  logic         accept,
    input  logic         composite,
    input  logic [W-1:0] new_word,
    output logic [W-1:0] word_out,
    output logic         word_stb,
    output logic         trs_n,
    output logic         eav_n
);
    localparam int unsigned D = N - 1;

    logic [W-1:0] dq [D];
    logic [D-1:0] tq;
    logic [D-1:0] eq;

    // Delay line, flag tags and the registered output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < D; k++) dq[k] <= '0;
            tq       <= '0;
            eq       <= '0;
            word_out <= '0;
            word_stb <= 1'b0;
            trs_n    <= 1'b1;
            eav_n    <= 1'b1;
        end else begin
            word_stb <= done;
            if (done && accept) begin
                word_out <= '1;
                trs_n    <= 1'b0;
                eav_n    <= 1'b1;
                dq[0]    <= new_word;
                for (int k = 1; k < D; k++) dq[k] <= '0;
                tq       <= '1;
                eq       <= {{(D-1){1'b0}}, new_word[HB]};
            end else if (done) begin
                word_out <= dq[D-1];
                trs_n    <= !tq[D-1];
                eav_n    <= !(eq[D-1] && !composite);
                dq[0]    <= new_word;
                for (int k = 1; k < D; k++) dq[k] <= dq[k-1];
                tq       <= {tq[D-2:0], 1'b0};
                eq       <= {eq[D-2:0], 1'b0};
            end
        end
    end

    // R3: a sequence opens with the all-ones word on a strobe
    p_trs_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trs_n) |-> (word_stb && word_out == '1));
    // R4: the end-of-video mark only falls inside a sequence
    p_eav_in_trs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !eav_n |-> !trs_n);
    // R5: composite mode never yields an end-of-video mark
    p_composite_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && !eav_n) |-> !$past(composite));
endmodule

// File: rtl/trs_word_framer.sv
// Top level: finds reference sequences in the serial stream and frames 10-bit
// words on them. It tags sequence words and the end-of-video word, and reports
// an off-boundary sequence on nsp.
// Assumes a decoded (descrambled, NRZ) input stream, one bit per valid cycle.
module trs_word_framer #(
    parameter int unsigned W  = sdv_frm_pkg::WORD_W_DEF,
    parameter int unsigned N  = sdv_frm_pkg::TRS_WORDS_DEF,
    parameter int unsigned HB = sdv_frm_pkg::H_BIT_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_bit,
    input  logic         ser_vld,
    input  logic         frame_en,
    input  logic         composite,
    output logic [W-1:0] word_out,
    output logic         word_stb,
    output logic         trs_n,
    output logic         eav_n,
    output logic         nsp
);
    logic         hit;
    logic [W-1:0] last_word;
    logic         done;
    logic         accept;
    logic         misaligned;

    trs_window #(.W(W), .N(N)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (ser_bit),
        .bit_vld   (ser_vld),
        .hit       (hit),
        .last_word (last_word)
    );

    word_phase #(.W(W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld    (ser_vld),
        .hit        (hit),
        .frame_en   (frame_en),
        .done       (done),
        .accept     (accept),
        .misaligned (misaligned)
    );

    word_pipe #(.W(W), .N(N), .HB(HB)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .accept    (accept),
        .composite (composite),
        .new_word  (last_word),
        .word_out  (word_out),
        .word_stb  (word_stb),
        .trs_n     (trs_n),
        .eav_n     (eav_n)
    );

    // New-sync-position flag, updated at every found sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)   nsp <= 1'b0;
        else if (hit) nsp <= misaligned;
    end

    // R8: off-boundary sequence raises nsp
    p_nsp_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |=> nsp);
    // R8: on-boundary sequence clears nsp
    p_nsp_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !misaligned) |=> !nsp);
endmodule

// File: tb/sim_trs_word_framer.sv
module sim_trs_word_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic       ser_vld = 1'b0;
    logic       frame_en = 1'b1;
    logic       composite = 1'b0;
    logic [9:0] word_out;
    logic       word_stb;
    logic       trs_n;
    logic       eav_n;
    logic       nsp;

    int checks = 0;
    int errors = 0;

    // Recorded strobes.
    logic [9:0] rw [512];
    logic       rt [512];
    logic       re [512];
    logic       rn [512];
    int         rec_n = 0;

    // Expected emitted sequence (from the first sequence word on).
    logic [9:0] sq [512];
    logic       st [512];
    logic       se [512];
    logic       sn [512];
    int         ns = 0;

    localparam logic [9:0] XYZ_EAV = 10'h274;  // bit 6 set
    localparam logic [9:0] XYZ_SAV = 10'h2AC;  // bit 6 clear

    always #4 clk = ~clk;  // 125 MHz

    trs_word_framer u0 (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_vld(ser_vld),
        .frame_en(frame_en), .composite(composite), .word_out(word_out),
        .word_stb(word_stb), .trs_n(trs_n), .eav_n(eav_n), .nsp(nsp)
    );

    // Capture each strobe away from the active edge.
    always @(negedge clk) begin
        if (rst_n && word_stb && rec_n < 512) begin
            rw[rec_n] = word_out;
            rt[rec_n] = trs_n;
            re[rec_n] = eav_n;
            rn[rec_n] = nsp;
            rec_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Data words: bit 4 set, bit 5 clear, so no ten-ones or twenty-zeros runs.
    function automatic logic [9:0] rand_data();
        return (10'($urandom) & 10'h3DF) | 10'h010;
    endfunction

    task automatic send_bit(input logic b);
        int gap;
        gap = ($urandom % 4 == 0) ? int'($urandom_range(1, 2)) : 0;
        ser_vld = 1'b0;
        repeat (gap) @(negedge clk);
        ser_bit = b;
        ser_vld = 1'b1;
        @(negedge clk);
        ser_vld = 1'b0;
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
    endtask

    // Lead-in bits with every fifth bit zero, so no sequence can form.
    task automatic send_junk(input int n);
        for (int i = 0; i < n; i++) send_bit((i % 5 == 4) ? 1'b0 : 1'($urandom));
    endtask

    task automatic push(input logic [9:0] w, input logic t, input logic e, input logic n);
        sq[ns] = w; st[ns] = t; se[ns] = e; sn[ns] = n;
        ns++;
    endtask

    task automatic send_trs(input logic [9:0] x, input logic comp, input logic n);
        send_word(10'h3FF); push(10'h3FF, 1'b1, 1'b0, n);
        send_word(10'h000); push(10'h000, 1'b1, 1'b0, n);
        send_word(10'h000); push(10'h000, 1'b1, 1'b0, n);
        send_word(x);       push(x, 1'b1, x[6] && !comp, n);
    endtask

    task automatic do_reset();
        ser_vld = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rec_n = 0;
        ns = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Framing on: lead-in, end-of-video sequence, data, start sequence, data.
    task automatic run_framed(input int junk, input logic comp, input int nd1, input int nd2);
        logic mis;
        int   f;
        logic [9:0] w;
        do_reset();
        frame_en = 1'b1;
        composite = comp;
        mis = (junk % 10) != 0;
        send_junk(junk);
        send_trs(XYZ_EAV, comp, mis);
        for (int i = 0; i < nd1; i++) begin w = rand_data(); send_word(w); push(w, 1'b0, 1'b0, mis); end
        send_trs(XYZ_SAV, comp, 1'b0);
        for (int i = 0; i < nd2; i++) begin w = rand_data(); send_word(w); push(w, 1'b0, 1'b0, 1'b0); end
        repeat (6) @(negedge clk);
        f = -1;
        for (int i = 0; i < rec_n; i++) if (f < 0 && !rt[i]) f = i;
        chk(f >= 0, "R2", "sequence found", f, 0);
        if (f >= 0) begin
            // R6: word count after realignment, no partial word inserted
            chk(rec_n - f == ns - 3, "R6", "words after sequence", rec_n - f, ns - 3);
            if (!mis) chk(f == junk / 10 + 3, "R9", "sequence strobe index", f, junk / 10 + 3);
            for (int i = 0; i < ns - 3 && f + i < rec_n; i++) begin
                chk(rw[f+i] == sq[i], "R6", "word", rw[f+i], sq[i]);
                chk(rt[f+i] == !st[i], "R3", "trs_n", rt[f+i], !st[i]);
                chk(re[f+i] == !se[i], comp ? "R5" : "R4", "eav_n", re[f+i], !se[i]);
                chk(rn[f+i] == sn[i], "R8", "nsp", rn[f+i], sn[i]);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd5813));
        // R10: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(word_out == 10'h0, "R10", "word_out", word_out, 0);
        chk(word_stb == 1'b0, "R10", "word_stb", word_stb, 0);
        chk(trs_n == 1'b1 && eav_n == 1'b1, "R10", "trs_n/eav_n", {trs_n, eav_n}, 3);
        chk(nsp == 1'b0, "R10", "nsp", nsp, 0);

        // Directed: off-boundary realignment, component.
        run_framed(23, 1'b0, 8, 8);
        // Directed: on-boundary, composite (R5), latency index (R9).
        run_framed(30, 1'b1, 6, 6);
        // Random lead-in offsets and modes.
        for (int r = 0; r < 6; r++)
            run_framed(int'($urandom_range(20, 39)), 1'($urandom),
                       int'($urandom_range(4, 10)), int'($urandom_range(4, 10)));

        // R7: framing off, off-boundary sequence leaves the boundary alone.
        do_reset();
        frame_en = 1'b0;
        composite = 1'b0;
        send_junk(27);
        send_trs(XYZ_EAV, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) send_word(rand_data());
        repeat (6) @(negedge clk);
        // R1 / R11: one strobe per ten accepted bits despite valid gaps
        chk(rec_n == 14, "R1", "strobe count (R7, R11)", rec_n, 14);
        begin
            int lows = 0;
            for (int i = 0; i < rec_n; i++) if (!rt[i] || !re[i]) lows++;
            chk(lows == 0, "R7", "flag lows without framing", lows, 0);
        end
        chk(nsp == 1'b1, "R8", "nsp after off-boundary sequence", nsp, 1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule